// File: doc/BRIEF.md
# Transmit Header Framer with Delimiter and Header Check

This block produces the serial bit stream that a transmitter sends right after the acquisition and training part of its preamble. A single start pulse captures a set of frame descriptor fields. The block then emits a fixed 16-bit frame delimiter and a 24-bit descriptor word packed from those fields. Next it sends a configurable number of header octets, which it pulls from an upstream byte stream. It ends with a 16-bit check word computed over the descriptor bits and the header octet bits together.

Every emitted bit carries a two-bit region tag, so that later stages (scrambling, spreading) can treat each part differently. The block also holds a flag for the whole frame that tells whether a body checksum will follow. If a descriptor is out of range, the block refuses to frame: no bit leaves the block and an error flag is raised instead.

Top module: `hdr_framer`

## Requirements
- R1: One cycle after a start pulse is accepted, the block emits the 16 delimiter bits 0000110010111101, leftmost first, one per cycle, tagged region 0.
- R2: Right after the delimiter, the 24-bit descriptor is sent with bit 0 first, tagged region 1. Layout: bits 1:0 seed select, bits 4:2 coding type, bit 5 interleaver select, bits 8:6 spreading length code, bit 9 modulation (0 two-phase, 1 bi-orthogonal), bits 23:10 body length in octets. Each field's least significant bit sits in the field's lowest position.
- R3: `mac_ready` stays low until all descriptor bits are out. The block then accepts exactly the captured number of octets through a `mac_valid`/`mac_ready` handshake and sends each one least significant bit first, tagged region 2.
- R4: The check word is a CRC over the descriptor bits followed by the octet bits in sending order. It uses generator x^16+x^12+x^5+1 (0x1021, shifted MSB-first), starts from 0xFFFF, and is sent inverted, most significant bit first, tagged region 3.
- R5: A start with body length above 4096, coding type 5, 6 or 7, or length code 7 sets `cfg_err` and emits no bit. `busy` and `mac_ready` stay low, and the next accepted start clears `cfg_err`.
- R6: A body length of exactly 4096 is accepted and framed normally.
- R7: `fcs_en` is high for the whole frame when the captured body length is nonzero and low when it is zero.
- R8: A start pulse while a frame is in progress, with any field values, is ignored and leaves the bit stream unchanged.
- R9: With an octet count of zero, the check word follows the descriptor directly, and its CRC covers only the descriptor.
- R10: `frame_done` is high only during the last check bit, and `busy` is low on the following cycle.
- R11: After reset, `bit_valid`, `mac_ready`, `busy`, `frame_done` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a frame with the current field values |
| seed_sel | input | 2 | Scrambler seed selector field |
| code_type | input | 3 | Coding type field |
| ilv_sel | input | 1 | Interleaver selector field |
| len_code | input | 3 | Spreading length code field |
| mod_sel | input | 1 | Modulation selector field |
| body_octets | input | 14 | Frame body length in octets |
| hdr_octets | input | 8 | Number of header octets to pull |
| mac_data | input | 8 | Header octet |
| mac_valid | input | 1 | Header octet present |
| mac_ready | output | 1 | Framer takes an octet this cycle |
| bit_out | output | 1 | Serial output bit |
| bit_valid | output | 1 | `bit_out` carries a bit this cycle |
| region | output | 2 | 0 delimiter, 1 descriptor, 2 header octet, 3 check word |
| fcs_en | output | 1 | Body checksum follows this frame |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | Last check bit this cycle |
| cfg_err | output | 1 | Last start was rejected |

## Verification
Two events can fall in the same cycle: the CRC register absorbing the last header bit, and the switch to sending the check word. The bench provokes this with frames whose octet count varies from zero upward, so that the last absorbed bit is sometimes a descriptor bit and sometimes an octet bit. Each case is judged by comparing the received check bits with a CRC that a bench function computes over exactly the expected descriptor and octet bits. A second coincidence, a new start pulse arriving during a live frame, is driven on purpose mid-descriptor, and the whole stream must still match the original frame.

// File: rtl/hdr_framer_pkg.sv
package hdr_framer_pkg;
    localparam int SFD_W    = 16;
    localparam int PHY_W    = 24;
    localparam int HCS_W    = 16;
    localparam int OCT_W    = 8;
    localparam int LEN_W    = 14;
    localparam int MAX_BODY = 4096;
    localparam int CNT_W    = $clog2(PHY_W);
    localparam logic [SFD_W-1:0] SFD_PATTERN = 16'b0000_1100_1011_1101;
    localparam logic [HCS_W-1:0] CRC_POLY    = 16'h1021;
    localparam logic [HCS_W-1:0] CRC_INIT    = 16'hFFFF;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SFD, ST_PHY, ST_MWAIT, ST_MBITS, ST_HCS
    } fr_state_e;

    typedef enum logic [1:0] {
        RG_SFD = 2'd0, RG_PHY = 2'd1, RG_MAC = 2'd2, RG_HCS = 2'd3
    } region_e;
endpackage

// File: rtl/hdr_cfg_check.sv
module hdr_cfg_check
    import hdr_framer_pkg::*;
(
    input  logic [1:0]       seed_sel,
    input  logic [2:0]       code_type,
    input  logic             ilv_sel,
    input  logic [2:0]       len_code,
    input  logic             mod_sel,
    input  logic [LEN_W-1:0] body_octets,
    output logic             cfg_ok,
    output logic [PHY_W-1:0] hdr_word
);
    logic code_bad;
    logic len_bad;
    logic body_bad;

    always_comb begin
        code_bad = (code_type > 3'd4);
        len_bad  = (len_code == 3'd7);
        body_bad = (32'(body_octets) > MAX_BODY);
        cfg_ok   = !(code_bad || len_bad || body_bad);
        hdr_word = {body_octets, mod_sel, len_code, ilv_sel, code_type, seed_sel};
    end
endmodule

// File: rtl/hdr_crc16.sv
module hdr_crc16
    import hdr_framer_pkg::*;
#(
    parameter int               W    = HCS_W,
    parameter logic [W-1:0]     POLY = CRC_POLY,
    parameter logic [W-1:0]     INIT = CRC_INIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] crc
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb    = crc_q[W-1] ^ din;
        crc_d = crc_q;
        if (clr) begin
            crc_d = INIT;
        end else if (en) begin
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= INIT;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/hdr_framer.sv
module hdr_framer
    import hdr_framer_pkg::*;
#(
    parameter int CNT_OCT_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [1:0]           seed_sel,
    input  logic [2:0]           code_type,
    input  logic                 ilv_sel,
    input  logic [2:0]           len_code,
    input  logic                 mod_sel,
    input  logic [LEN_W-1:0]     body_octets,
    input  logic [CNT_OCT_W-1:0] hdr_octets,
    input  logic [OCT_W-1:0]     mac_data,
    input  logic                 mac_valid,
    output logic                 mac_ready,
    output logic                 bit_out,
    output logic                 bit_valid,
    output logic [1:0]           region,
    output logic                 fcs_en,
    output logic                 busy,
    output logic                 frame_done,
    output logic                 cfg_err
);
    localparam logic [CNT_W-1:0] SFD_LAST = CNT_W'(SFD_W - 1);
    localparam logic [CNT_W-1:0] PHY_LAST = CNT_W'(PHY_W - 1);
    localparam logic [CNT_W-1:0] OCT_LAST = CNT_W'(OCT_W - 1);
    localparam logic [CNT_W-1:0] HCS_LAST = CNT_W'(HCS_W - 1);

    typedef struct packed {
        fr_state_e            st;
        logic [CNT_W-1:0]     cnt;
        logic [PHY_W-1:0]     hdr;
        logic [OCT_W-1:0]     byt;
        logic [CNT_OCT_W-1:0] left;
        logic                 fcs;
        logic                 err;
    } fr_regs_t;

    fr_regs_t r_d, r_q;

    logic             cfg_ok;
    logic [PHY_W-1:0] hdr_word;
    logic [HCS_W-1:0] crc;
    logic             crc_clr;
    logic             crc_en;
    logic             cur_bit;
    logic [CNT_W-1:0] rev_idx;

    hdr_cfg_check u_cfg (
        .seed_sel    (seed_sel),
        .code_type   (code_type),
        .ilv_sel     (ilv_sel),
        .len_code    (len_code),
        .mod_sel     (mod_sel),
        .body_octets (body_octets),
        .cfg_ok      (cfg_ok),
        .hdr_word    (hdr_word)
    );

    hdr_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (cur_bit),
        .crc   (crc)
    );

    // current serial bit, chosen from the part being sent
    always_comb begin
        rev_idx = SFD_LAST - r_q.cnt;
        cur_bit = 1'b0;
        unique case (r_q.st)
            ST_SFD:   cur_bit = SFD_PATTERN[rev_idx[3:0]];
            ST_PHY:   cur_bit = r_q.hdr[r_q.cnt];
            ST_MBITS: cur_bit = r_q.byt[r_q.cnt[2:0]];
            ST_HCS:   cur_bit = ~crc[rev_idx[3:0]];
            default:  cur_bit = 1'b0;
        endcase
    end

    // next-state computation
    always_comb begin
        r_d     = r_q;
        crc_clr = 1'b0;
        crc_en  = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    if (!cfg_ok) begin
                        r_d.err = 1'b1;
                    end else begin
                        r_d.err  = 1'b0;
                        r_d.st   = ST_SFD;
                        r_d.cnt  = '0;
                        r_d.hdr  = hdr_word;
                        r_d.left = hdr_octets;
                        r_d.fcs  = (body_octets != '0);
                        crc_clr  = 1'b1;
                    end
                end
            end
            ST_SFD: begin
                if (r_q.cnt == SFD_LAST) begin
                    r_d.st  = ST_PHY;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_PHY: begin
                crc_en = 1'b1;
                if (r_q.cnt == PHY_LAST) begin
                    r_d.st  = (r_q.left == '0) ? ST_HCS : ST_MWAIT;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_MWAIT: begin
                if (mac_valid) begin
                    r_d.byt  = mac_data;
                    r_d.left = r_q.left - 1'b1;
                    r_d.st   = ST_MBITS;
                    r_d.cnt  = '0;
                end
            end
            ST_MBITS: begin
                crc_en = 1'b1;
                if (r_q.cnt == OCT_LAST) begin
                    r_d.st  = (r_q.left == '0) ? ST_HCS : ST_MWAIT;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_HCS: begin
                if (r_q.cnt == HCS_LAST) begin
                    r_d.st  = ST_IDLE;
                    r_d.cnt = '0;
                    r_d.fcs = 1'b0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // outputs depend on registered state only
    always_comb begin
        bit_out    = cur_bit;
        bit_valid  = (r_q.st == ST_SFD) || (r_q.st == ST_PHY) ||
                     (r_q.st == ST_MBITS) || (r_q.st == ST_HCS);
        mac_ready  = (r_q.st == ST_MWAIT);
        busy       = (r_q.st != ST_IDLE);
        fcs_en     = r_q.fcs && busy;
        frame_done = (r_q.st == ST_HCS) && (r_q.cnt == HCS_LAST);
        cfg_err    = r_q.err;
        unique case (r_q.st)
            ST_PHY:   region = RG_PHY;
            ST_MBITS: region = RG_MAC;
            ST_MWAIT: region = RG_MAC;
            ST_HCS:   region = RG_HCS;
            default:  region = RG_SFD;
        endcase
    end
endmodule

// File: rtl/hdr_framer_chk.sv
module hdr_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       mac_ready,
    input logic       bit_out,
    input logic       bit_valid,
    input logic [1:0] region,
    input logic       fcs_en,
    input logic       busy,
    input logic       frame_done,
    input logic       cfg_err
);
    // R1: a frame opens with a delimiter bit, and its first bit is zero
    p_sfd_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (bit_valid && region == 2'd0 && bit_out == 1'b0));

    // R3: octets are only taken while no bit is being sent
    p_ready_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mac_ready |-> (busy && !bit_valid));

    // R4: the final bit is a check-word bit
    p_done_hcs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (bit_valid && region == 2'd3));

    // R5: a rejected start leaves the framer idle
    p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!busy && !bit_valid && !mac_ready));

    // R7: the checksum flag does not move within a frame
    p_fcs_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(fcs_en));

    // R10: the framer is idle right after the last bit
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !busy);
endmodule

bind hdr_framer hdr_framer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mac_ready  (mac_ready),
    .bit_out    (bit_out),
    .bit_valid  (bit_valid),
    .region     (region),
    .fcs_en     (fcs_en),
    .busy       (busy),
    .frame_done (frame_done),
    .cfg_err    (cfg_err)
);

// File: tb/hdr_framer_bench.sv
module hdr_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  seed_sel = '0;
    logic [2:0]  code_type = '0;
    logic        ilv_sel = 1'b0;
    logic [2:0]  len_code = '0;
    logic        mod_sel = 1'b0;
    logic [13:0] body_octets = '0;
    logic [7:0]  hdr_octets = '0;
    logic [7:0]  mac_data = '0;
    logic        mac_valid = 1'b0;
    logic        mac_ready, bit_out, bit_valid, fcs_en, busy, frame_done, cfg_err;
    logic [1:0]  region;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] mbytes [0:63];
    logic       eb [0:1023];
    logic [1:0] er [0:1023];
    logic       ab [0:1023];
    logic [1:0] ar [0:1023];

    always #5 clk = ~clk;

    hdr_framer u_hdr_framer (
        .clk(clk), .rst_n(rst_n), .start(start), .seed_sel(seed_sel),
        .code_type(code_type), .ilv_sel(ilv_sel), .len_code(len_code),
        .mod_sel(mod_sel), .body_octets(body_octets), .hdr_octets(hdr_octets),
        .mac_data(mac_data), .mac_valid(mac_valid), .mac_ready(mac_ready),
        .bit_out(bit_out), .bit_valid(bit_valid), .region(region),
        .fcs_en(fcs_en), .busy(busy), .frame_done(frame_done), .cfg_err(cfg_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] pack_desc(input logic [1:0] sd, input logic [2:0] ct,
            input logic il, input logic [2:0] lc, input logic md, input logic [13:0] bl);
        logic [23:0] w;
        w[1:0] = sd; w[4:2] = ct; w[5] = il; w[8:6] = lc; w[9] = md; w[23:10] = bl;
        return w;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
        return c;
    endfunction

    task automatic run_frame(input logic [1:0] sd, input logic [2:0] ct, input logic il,
                             input logic [2:0] lc, input logic md, input logic [13:0] bl,
                             input logic [7:0] nm, input bit poke);
        logic [15:0] sfd;
        logic [23:0] dw;
        logic [15:0] c;
        int n_exp, got, midx, cyc, mm;
        bit early, fcs_bad, done;
        sfd = 16'b0000_1100_1011_1101;
        dw = pack_desc(sd, ct, il, lc, md, bl);
        n_exp = 0;
        for (int i = 0; i < 16; i++) begin eb[n_exp] = sfd[15-i]; er[n_exp] = 2'd0; n_exp++; end
        for (int i = 0; i < 24; i++) begin eb[n_exp] = dw[i]; er[n_exp] = 2'd1; n_exp++; end
        for (int k = 0; k < int'(nm); k++)
            for (int i = 0; i < 8; i++) begin eb[n_exp] = mbytes[k][i]; er[n_exp] = 2'd2; n_exp++; end
        c = 16'hFFFF;
        for (int i = 16; i < n_exp; i++) c = crc_step(c, eb[i]);
        for (int i = 0; i < 16; i++) begin eb[n_exp] = ~c[15-i]; er[n_exp] = 2'd3; n_exp++; end

        @(negedge clk);
        seed_sel = sd; code_type = ct; ilv_sel = il; len_code = lc; mod_sel = md;
        body_octets = bl; hdr_octets = nm; start = 1'b1;
        got = 0; midx = 0; cyc = 0; early = 0; fcs_bad = 0; done = 0;
        while (!done && cyc < 4000) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (poke && got == 30) begin // R8: stray start with other fields
                start = 1'b1; code_type = 3'd1; len_code = 3'd2; body_octets = 14'd0;
                hdr_octets = 8'd3; seed_sel = ~sd;
            end
            if (bit_valid && got < 1024) begin
                ab[got] = bit_out; ar[got] = region; got++;
                if (fcs_en != (bl != 0)) fcs_bad = 1;
            end
            if (frame_done) done = 1;
            if (mac_ready && got < 40) early = 1;
            mac_valid = (($urandom % 3) != 0);
            mac_data = mbytes[midx];
            if (mac_valid && mac_ready) midx++;
        end
        mac_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        check(!busy && done, "R10", "idle after last check bit", int'(busy), 0);
        check(got == n_exp, "R9", "frame bit count", got, n_exp);
        mm = 0;
        for (int i = 0; i < 16; i++) if (ab[i] !== eb[i] || ar[i] !== er[i]) mm++;
        check(mm == 0, "R1", "delimiter mismatches", mm, 0);
        mm = 0;
        for (int i = 16; i < 40; i++) if (ab[i] !== eb[i] || ar[i] !== er[i]) mm++;
        check(mm == 0, poke ? "R8" : "R2", "descriptor mismatches", mm, 0);
        mm = 0;
        for (int i = 40; i < n_exp - 16; i++) if (ab[i] !== eb[i] || ar[i] !== er[i]) mm++;
        check(mm == 0, "R3", "octet bit mismatches", mm, 0);
        check(!early, "R3", "ready before descriptor end", int'(early), 0);
        check(midx == int'(nm), "R3", "octets taken", midx, int'(nm));
        mm = 0;
        for (int i = n_exp - 16; i < n_exp; i++) if (ab[i] !== eb[i] || ar[i] !== er[i]) mm++;
        check(mm == 0, "R4", "check word mismatches", mm, 0);
        check(!fcs_bad, "R7", "fcs_en level", int'(fcs_bad), 0);
        check(!cfg_err, "R5", "error cleared by good start", int'(cfg_err), 0);
    endtask

    task automatic run_bad(input logic [2:0] ct, input logic [2:0] lc, input logic [13:0] bl);
        bit seen;
        @(negedge clk);
        code_type = ct; len_code = lc; body_octets = bl; hdr_octets = 8'd2; start = 1'b1;
        seen = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (bit_valid || mac_ready || busy) seen = 1;
        end
        check(!seen, "R5", "activity after rejected start", int'(seen), 0);
        check(cfg_err, "R5", "cfg_err after rejected start", int'(cfg_err), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 64; i++) mbytes[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        // R11: reset values
        check(!bit_valid && !mac_ready && !busy && !frame_done && !cfg_err, "R11",
              "outputs during reset", int'({bit_valid, mac_ready, busy, frame_done, cfg_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!bit_valid && !busy && !cfg_err, "R11", "outputs after reset",
              int'({bit_valid, busy, cfg_err}), 0);

        run_frame(2'd1, 3'd1, 1'b0, 3'd0, 1'b0, 14'd100, 8'd4, 0);
        run_frame(2'd3, 3'd4, 1'b1, 3'd6, 1'b1, 14'd4096, 8'd2, 0); // R6 boundary
        run_frame(2'd0, 3'd0, 1'b0, 3'd5, 1'b0, 14'd0, 8'd0, 0);    // R9, R7 zero length
        run_frame(2'd2, 3'd2, 1'b0, 3'd1, 1'b1, 14'd37, 8'd3, 1);   // R8 stray start
        run_bad(3'd1, 3'd0, 14'd4097);
        run_bad(3'd5, 3'd0, 14'd10);
        run_bad(3'd7, 3'd2, 14'd10);
        run_bad(3'd0, 3'd7, 14'd10);
        run_frame(2'd1, 3'd3, 1'b0, 3'd2, 1'b0, 14'd1, 8'd1, 0);    // clears cfg_err
        for (int f = 0; f < 8; f++) begin
            for (int i = 0; i < 64; i++) mbytes[i] = 8'($urandom);
            run_frame(2'($urandom), 3'($urandom % 5), 1'($urandom), 3'($urandom % 7),
                      1'($urandom), 14'($urandom % 4097), 8'($urandom % 9), 0);
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule